// File: doc/BRIEF.md
# Tagged Word-to-Byte Unpacker

The unpacker takes 32-bit words that each carry between one and four payload bytes and turns them into a stream of single bytes. Words enter through a valid/ready port together with a 4-bit channel tag. Bytes leave through a second valid/ready port, lowest lane first. The tag of the source word and a flag that marks the final byte of that word travel with every byte.

The word has no length field. The unpacker finds the byte count by testing the upper bytes against fixed marker values in a set order. A word is held in one register until every byte of it has been taken. The next word is accepted on the same clock edge that takes the final byte, so a steady supply of words leaves no gap in the byte stream.

Top module: `word_unpacker`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: When word bits 31:8 equal 0x808080, exactly one byte is emitted, equal to bits 7:0.
- R3: Otherwise, when bits 31:16 equal 0x8181, two bytes are emitted: bits 7:0, then bits 15:8.
- R4: Otherwise, when bits 31:24 equal 0x82, three bytes are emitted: bits 7:0, 15:8 and 23:16, in that order.
- R5: In every other case, four bytes are emitted from lane 0 (bits 7:0) up to lane 3 (bits 31:24).
- R6: in_ready is high only when no byte of the held word is waiting, or when the last waiting byte is taken in the same cycle. out_valid is high exactly while bytes are waiting.
- R7: Every emitted byte carries the tag that came with its word. out_last is high on the final byte of a word and low on all earlier bytes.
- R8: While out_valid is high and out_ready is low, out_byte, out_tag and out_last hold their values, and out_valid stays high.
- R9: A word accepted in a cycle gives out_valid high in the next cycle, so back-to-back words leave no idle cycle.
- R10: The marker tests have a fixed priority. 0x81818080 yields two bytes, 0x82808080 three bytes and 0x82818180 three bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An encoded word is offered |
| in_ready | output | 1 | The unpacker accepts the offered word this cycle |
| in_word | input | 32 | Encoded word |
| in_tag | input | TAG_W (4) | Channel tag of the offered word |
| out_valid | output | 1 | A payload byte is presented |
| out_ready | input | 1 | The receiver takes the presented byte |
| out_byte | output | 8 | Payload byte |
| out_tag | output | TAG_W (4) | Tag of the word the byte came from |
| out_last | output | 1 | The byte is the final one of its word |

## Verification
The hardest case is the hand-over edge. Here the last byte of one word is taken while the next word is already waiting, so ready on the input side depends on ready on the output side within the same cycle. Directed words with out_ready held high run back to back. A constrained-random phase then varies the input valid and the output ready independently, which repeatedly hits this edge, both with and without a stall on its last byte. Marker-like words that test the decoding priority are also fed in: a lower byte equals a marker value while a higher byte selects a shorter length.

// File: rtl/wup_pkg.sv
package wup_pkg;
  localparam int WUP_BYTE_W = 8;
  localparam int WUP_LANES  = 4;
  localparam int WUP_WORD_W = WUP_BYTE_W * WUP_LANES;
  localparam int WUP_IDX_W  = $clog2(WUP_LANES);
  localparam int WUP_CNT_W  = $clog2(WUP_LANES + 1);

  // marker values placed in the unused upper lanes
  localparam logic [WUP_BYTE_W-1:0] MARK_SINGLE = 8'h80;
  localparam logic [WUP_BYTE_W-1:0] MARK_PAIR   = 8'h81;
  localparam logic [WUP_BYTE_W-1:0] MARK_TRIPLE = 8'h82;

  typedef logic [WUP_CNT_W-1:0] wup_cnt_t;
  typedef logic [WUP_IDX_W-1:0] wup_idx_t;

  // number of payload bytes in an encoded word, tested in priority order
  function automatic wup_cnt_t wup_byte_count(input logic [WUP_WORD_W-1:0] w);
    wup_cnt_t n;
    if (w[31:8] == {3{MARK_SINGLE}})
      n = wup_cnt_t'(1);
    else if (w[31:16] == {2{MARK_PAIR}})
      n = wup_cnt_t'(2);
    else if (w[31:24] == MARK_TRIPLE)
      n = wup_cnt_t'(3);
    else
      n = wup_cnt_t'(WUP_LANES);
    return n;
  endfunction
endpackage

// File: rtl/wup_len_dec.sv
module wup_len_dec
  import wup_pkg::*;
(
  input  logic [WUP_WORD_W-1:0] word_i,
  output wup_idx_t              last_idx_o
);
  wup_cnt_t cnt;
  always_comb begin
    cnt        = wup_byte_count(word_i);
    last_idx_o = wup_idx_t'(cnt - wup_cnt_t'(1));
  end
endmodule

// File: rtl/wup_lane_sel.sv
module wup_lane_sel #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES*BYTE_W-1:0] word_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [BYTE_W-1:0]       byte_o
);
  logic [BYTE_W-1:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
  end
  assign byte_o = lane[idx_i];
endmodule

// File: rtl/wup_drain_ctl.sv
module wup_drain_ctl
  import wup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  wup_idx_t load_last_idx_i,
  input  logic     take_i,
  output logic     busy_o,
  output wup_idx_t idx_o,
  output logic     last_o
);
  wup_idx_t last_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      idx_o      <= '0;
      last_idx_q <= '0;
    end else if (load_i) begin
      busy_o     <= 1'b1;
      idx_o      <= '0;
      last_idx_q <= load_last_idx_i;
    end else if (take_i) begin
      if (last_o) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + wup_idx_t'(1);
      end
    end
  end

  assign last_o = busy_o && (idx_o == last_idx_q);
endmodule

// File: rtl/word_unpacker.sv
module word_unpacker
  import wup_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WUP_WORD_W-1:0] in_word,
  input  logic [TAG_W-1:0]      in_tag,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WUP_BYTE_W-1:0] out_byte,
  output logic [TAG_W-1:0]      out_tag,
  output logic                  out_last
);
  logic [WUP_WORD_W-1:0] word_q;
  logic [TAG_W-1:0]      tag_q;
  wup_idx_t              dec_last_idx;
  wup_idx_t              cur_idx;
  logic                  busy;
  logic                  last;

  // named events, also observed by the bound checker
  logic load_evt;
  logic take_evt;

  assign take_evt = busy && out_ready;
  assign in_ready = !busy || (take_evt && last);
  assign load_evt = in_valid && in_ready;

  wup_len_dec u_dec (
    .word_i     (in_word),
    .last_idx_o (dec_last_idx)
  );

  wup_drain_ctl u_ctl (
    .clk             (clk),
    .rst_n           (rst_n),
    .load_i          (load_evt),
    .load_last_idx_i (dec_last_idx),
    .take_i          (take_evt),
    .busy_o          (busy),
    .idx_o           (cur_idx),
    .last_o          (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      tag_q  <= '0;
    end else if (load_evt) begin
      word_q <= in_word;
      tag_q  <= in_tag;
    end
  end

  wup_lane_sel #(.LANES(WUP_LANES), .BYTE_W(WUP_BYTE_W)) u_sel (
    .word_i (word_q),
    .idx_i  (cur_idx),
    .byte_o (out_byte)
  );

  assign out_valid = busy;
  assign out_tag   = tag_q;
  assign out_last  = last;
endmodule

// File: rtl/wup_chk.sv
module wup_chk
  import wup_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [WUP_WORD_W-1:0] in_word,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WUP_BYTE_W-1:0] out_byte,
  input logic [TAG_W-1:0]      out_tag,
  input logic                  out_last,
  input logic                  load_evt,
  input logic                  take_evt
);
  logic [2:0] exp_n;
  logic [2:0] seen_n;
  logic [2:0] dec_n;

  // independent length view: count marker matches from the top down
  always_comb begin
    if (in_word[31:24] == 8'h82) dec_n = 3'd3;
    else if (in_word[31:24] == 8'h81 && in_word[23:16] == 8'h81) dec_n = 3'd2;
    else if (in_word[31:24] == 8'h80 && in_word[23:16] == 8'h80 && in_word[15:8] == 8'h80) dec_n = 3'd1;
    else dec_n = 3'd4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_n  <= 3'd0;
      seen_n <= 3'd0;
    end else if (load_evt) begin
      exp_n  <= dec_n;
      seen_n <= 3'd0;
    end else if (take_evt) begin
      seen_n <= seen_n + 3'd1;
    end
  end

  // R6
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || (out_ready && out_last)));

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_tag) && $stable(out_last)));

  // R9
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && out_last) |-> (3'(seen_n + 3'd1) == exp_n));

  // R7
  early_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && !out_last) |-> (3'(seen_n + 3'd1) < exp_n));
endmodule

bind word_unpacker wup_chk #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte),
  .out_tag   (out_tag),
  .out_last  (out_last),
  .load_evt  (load_evt),
  .take_evt  (take_evt)
);

// File: tb/sim_word_unpacker.sv
`timescale 1ns/1ps
module sim_word_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [3:0]  in_tag = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;
  logic [3:0]  out_tag;
  logic        out_last;

  always #2.5 clk = ~clk;

  word_unpacker u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_tag(out_tag), .out_last(out_last)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [7:0] qb[$];
  logic [3:0] qt[$];
  logic       ql[$];
  string      qr[$];

  bit         acc_prev = 0;
  bit         stall_prev = 0;
  logic [7:0] s_byte;
  logic [3:0] s_tag;
  logic       s_last;
  bit         loaded;

  // byte count restated from the requirements, lowest marker lane first
  function automatic int word_len(input logic [31:0] w);
    if (w[15:8] == 8'h80 && w[23:16] == 8'h80 && w[31:24] == 8'h80) return 1;
    if (w[23:16] == 8'h81 && w[31:24] == 8'h81) return 2;
    if (w[31:24] == 8'h82) return 3;
    return 4;
  endfunction

  function automatic string word_req(input logic [31:0] w);
    if (w == 32'h81818080 || w == 32'h82808080 || w == 32'h82818180) return "R10";
    case (word_len(w))
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [31:0] rnd_word();
    logic [31:0] r = $urandom();
    case ($urandom() % 6)
      0: return {24'h808080, r[7:0]};
      1: return {16'h8181, r[15:0]};
      2: return {8'h82, r[23:0]};
      3: return {8'h80, 8'h80, r[15:0]};
      4: return {8'h81, r[23:0]};
      default: return r;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit v_new, input logic [31:0] w_new,
                       input logic [3:0] t_new, input bit rdy);
    bit exp_rdy;
    @(negedge clk);
    loaded = 0;
    if (!in_valid || acc_prev) begin
      in_valid = v_new;
      in_word  = w_new;
      in_tag   = t_new;
      loaded   = v_new;
    end
    out_ready = rdy;
    #1;
    exp_rdy = (qb.size() == 0) || (qb.size() == 1 && out_ready);
    check(in_ready == exp_rdy, "R6", "in_ready", 32'(in_ready), 32'(exp_rdy));
    check(out_valid == (qb.size() != 0), "R6", "out_valid", 32'(out_valid), 32'(qb.size() != 0));
    if (acc_prev)
      check(out_valid == 1'b1, "R9", "out_valid after accept", 32'(out_valid), 32'd1);
    if (stall_prev && out_valid) begin
      check(out_byte == s_byte && out_tag == s_tag && out_last == s_last, "R8", "held output",
            {19'd0, out_last, out_tag, out_byte}, {19'd0, s_last, s_tag, s_byte});
    end
    if (out_valid && qb.size() != 0) begin
      check(out_byte == qb[0], qr[0], "byte", 32'(out_byte), 32'(qb[0]));
      check(out_tag == qt[0], "R7", "tag", 32'(out_tag), 32'(qt[0]));
      check(out_last == ql[0], "R7", "last", 32'(out_last), 32'(ql[0]));
    end
    stall_prev = out_valid && !out_ready;
    s_byte = out_byte; s_tag = out_tag; s_last = out_last;
    if (out_valid && out_ready && qb.size() != 0) begin
      void'(qb.pop_front()); void'(qt.pop_front());
      void'(ql.pop_front()); void'(qr.pop_front());
    end
    acc_prev = in_valid && in_ready;
    if (acc_prev) begin
      for (int i = 0; i < word_len(in_word); i++) begin
        qb.push_back(in_word[8*i +: 8]);
        qt.push_back(in_tag);
        ql.push_back(i == word_len(in_word) - 1);
        qr.push_back(word_req(in_word));
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] dir [10];
    int di;
    void'($urandom(32'd20240611));
    dir[0] = 32'h80808041; dir[1] = 32'h81814342; dir[2] = 32'h82454443;
    dir[3] = 32'h44434241; dir[4] = 32'h80808080; dir[5] = 32'h81818080;
    dir[6] = 32'h82808080; dir[7] = 32'h82818180; dir[8] = 32'h80818283;
    dir[9] = 32'h8080807f;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    // directed, back to back with receiver always ready
    di = 0;
    while (di < 10) begin
      cycle(1'b1, dir[di], 4'(di), 1'b1);
      if (loaded) di++;
    end
    // directed again with stalls on the output
    di = 0;
    while (di < 10) begin
      cycle(1'b1, dir[di], 4'(15 - di), ($urandom() % 2) == 0);
      if (loaded) di++;
    end
    // constrained random
    for (int k = 0; k < 6000; k++)
      cycle(($urandom() % 4) != 0, rnd_word(), 4'($urandom()), ($urandom() % 3) != 0);
    // drain
    for (int k = 0; k < 12; k++)
      cycle(1'b0, 32'd0, 4'd0, 1'b1);
    check(qb.size() == 0, "R6", "all bytes delivered", 32'(qb.size()), 32'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule